// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Holding-Empty Timing

This block turns parallel bytes into an asynchronous serial bit stream. Bytes are written into a holding store. In queued mode the store is a 16-entry first-in first-out buffer; in single mode it is one register. A shift engine sends each byte as a frame on a line that rests high. Time is counted on a 16x oversampling enable (`baud_tick`), so one bit lasts 16 ticks.

The frame settings are chosen per character:
- 5 to 8 data bits, sent least significant bit first.
- An optional even or odd parity bit.
- One stop bit, two stop bits, or one and a half stop bits when the character is 5 bits long.

A break input forces the line low.

Two outputs tell the host when to send more data. Both act a fixed 8 ticks into a start bit, and only when the holding store is empty at that moment:
- A holding-empty interrupt. It is cleared by a write, or by an interrupt-identity read while it is pending.
- A DMA ready request.

When an idle transmitter takes its first byte, the start bit is held back to a tick-phase boundary. As a result, the first interrupt arrives 16 to 24 ticks after the write.

Top module: `sertx_core`

## Requirements
- R1: While reset is low and right after it is released, `tx_out` is 1, `tx_irq` is 0 and `dma_rdy` is 1.
- R2: A frame begins with a start bit at 0 lasting 16 ticks. Then follow N data bits, least significant first, each lasting 16 ticks. N = 5 + `char_len`: 00→5, 01→6, 10→7, 11→8.
- R3: With `par_en`=1, one parity bit follows the data. With `par_even`=1 it makes the count of ones in data plus parity even. With `par_even`=0 it makes that count odd. With `par_en`=0 no parity bit is sent.
- R4: The stop level is 1. It lasts 16 ticks when `stop_long`=0. When `stop_long`=1 it lasts 24 ticks for 5-bit characters and 32 ticks otherwise. When the store still holds a byte at the end of the stop, the next start bit begins on the following tick.
- R5: While `brk`=1, `tx_out` is 0 from the next clock on. After `brk` falls, an idle line returns to 1.
- R6: With `fifo_mode`=1, up to 16 bytes are held and sent in write order. A write while 16 are held is dropped.
- R7: With `fifo_mode`=0, one byte is held. A write while it is occupied is dropped.
- R8: The holding-empty state is set 8 ticks after a start bit begins, if the store is empty then. `tx_irq` shows this state only while `irq_en`=1; the state is kept while masked.
- R9: After a single write to an idle transmitter, `tx_irq` rises between 16 and 24 ticks after the write.
- R10: Any `wr_en` pulse clears the holding-empty state. An `iid_rd` pulse while the state is set also clears it.
- R11: `dma_rdy` goes to 0 on a write in single mode, or when the store is full in queued mode. It returns to 1 at the same point as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | 16x bit-rate enable, one clock wide |
| fifo_mode | input | 1 | 1: 16-entry queue, 0: single holding register |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Send a parity bit |
| par_even | input | 1 | 1: even parity, 0: odd parity |
| stop_long | input | 1 | Long stop (1.5 or 2 bits) |
| brk | input | 1 | Force the line low |
| irq_en | input | 1 | Unmask the holding-empty interrupt |
| wr_en | input | 1 | Holding write strobe |
| wr_data | input | 8 | Byte to send |
| iid_rd | input | 1 | Interrupt-identity read strobe |
| tx_out | output | 1 | Serial line |
| tx_irq | output | 1 | Holding-empty interrupt |
| dma_rdy | output | 1 | DMA ready request, active high |

## Verification
The framing engine is tried with all four lengths, with no, even and odd parity, and with both stop settings, each under back-to-back character pairs. The pairs separate the stop duration from the idle gap, and they separate bit order from parity polarity. Data values with unequal counts of ones catch a swapped parity sense. A 17-byte burst and a two-write burst in single mode tell dropped writes apart from stored ones. Single characters tell the 16-to-24-tick first-interrupt window apart from the steady 8-tick point. Pairs show that the interrupt is suppressed while the store still holds a byte.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_mode,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          avail,
    output logic          full
);
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTRW-1:0] wp;
        logic [PTRW-1:0] rp;
        logic [CNTW-1:0] cnt;
    } hold_t;

    hold_t q, n;
    logic [DW-1:0] mem [DEPTH];
    logic do_wr, do_rd;

    always_comb begin
        n     = q;
        full  = fifo_mode ? (q.cnt == CNTW'(DEPTH)) : (q.cnt != '0);
        avail = (q.cnt != '0);
        do_wr = wr_en && !full;
        do_rd = rd_en && avail;
        if (do_wr) n.wp = (q.wp == PTRW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        if (do_rd) n.rp = (q.rp == PTRW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        case ({do_wr, do_rd})
            2'b10:   n.cnt = q.cnt + 1'b1;
            2'b01:   n.cnt = q.cnt - 1'b1;
            default: n.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[q.wp] <= wr_data;
    end

    assign rd_data = mem[q.rp];

    // R6/R7: a write into a full store leaves the occupancy unchanged
    a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> $stable(q.cnt));

    // R6: occupancy never exceeds the depth
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNTW'(DEPTH));

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          brk,
    input  logic [1:0]    char_len,
    input  logic          par_en,
    input  logic          par_even,
    input  logic          stop_long,
    input  logic          hold_avail,
    input  logic [DW-1:0] hold_data,
    output logic          hold_pop,
    output logic          mid_start,
    output logic          tx_out
);
    localparam int HALF = OVS / 2;
    localparam int CW   = $clog2(2 * OVS) + 1;
    localparam int PW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int AW   = $clog2(HALF) + 1;
    localparam int BW   = $clog2(DW);

    typedef struct packed {
        tx_state_e      st;
        logic [CW-1:0]  cnt;
        logic [BW-1:0]  idx;
        logic [BW-1:0]  last;
        logic [DW-1:0]  sreg;
        logic           pbit;
        logic           pen;
        logic [CW-1:0]  stop_n;
        logic [PW-1:0]  ph;
        logic [AW-1:0]  arm;
        logic           tx;
    } sh_t;

    sh_t q, n;
    logic load, bit_end;
    logic [BW-1:0] new_last;
    logic [DW-1:0] new_mask;

    always_comb begin
        n         = q;
        load      = 1'b0;
        mid_start = 1'b0;
        bit_end   = baud_tick && (q.cnt == CW'(OVS - 1));
        new_last  = BW'(char_len) + BW'(DW - 4);
        new_mask  = {DW{1'b1}} >> (BW'(DW - 1) - new_last);

        if (baud_tick) n.ph = q.ph + 1'b1;

        case (q.st)
            ST_IDLE: begin
                if (hold_avail) begin
                    n.st  = ST_ARM;
                    n.arm = '0;
                end
            end
            ST_ARM: begin
                if (baud_tick) begin
                    if (q.arm >= AW'(HALF - 1) && q.ph == PW'(HALF - 1)) load = 1'b1;
                    else if (q.arm != AW'(HALF))                         n.arm = q.arm + 1'b1;
                end
            end
            ST_START: begin
                if (baud_tick) begin
                    if (q.cnt == CW'(HALF - 1)) mid_start = 1'b1;
                    if (bit_end) begin
                        n.st  = ST_DATA;
                        n.cnt = '0;
                        n.idx = '0;
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    n.cnt  = '0;
                    n.sreg = q.sreg >> 1;
                    if (q.idx == q.last) n.st  = q.pen ? ST_PAR : ST_STOP;
                    else                 n.idx = q.idx + 1'b1;
                end else if (baud_tick) begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            ST_PAR: begin
                if (bit_end) begin
                    n.st  = ST_STOP;
                    n.cnt = '0;
                end else if (baud_tick) begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            ST_STOP: begin
                if (baud_tick) begin
                    if (q.cnt == q.stop_n - 1'b1) begin
                        if (hold_avail) load = 1'b1;
                        else            n.st = ST_IDLE;
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: n.st = ST_IDLE;
        endcase

        if (load) begin
            n.st   = ST_START;
            n.cnt  = '0;
            n.idx  = '0;
            n.sreg = hold_data;
            n.last = new_last;
            n.pen  = par_en;
            n.pbit = par_even ? (^(hold_data & new_mask)) : ~(^(hold_data & new_mask));
            if (!stop_long)          n.stop_n = CW'(OVS);
            else if (char_len == '0) n.stop_n = CW'(OVS + HALF);
            else                     n.stop_n = CW'(2 * OVS);
        end
        hold_pop = load;

        case (n.st)
            ST_START: n.tx = 1'b0;
            ST_DATA:  n.tx = n.sreg[0];
            ST_PAR:   n.tx = n.pbit;
            default:  n.tx = 1'b1;
        endcase
        if (brk) n.tx = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
            q.tx <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign tx_out = q.tx;

    // R5: break drives the line low on the next clock
    a_r5_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> !tx_out);

    // R1: an idle engine with nothing to send keeps the line high
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !hold_avail && !brk) |=> tx_out);

    // R2: bit timing only moves on an oversampling tick
    a_r2_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && q.st != ST_IDLE && q.st != ST_ARM) |=> $stable(q.cnt));

endmodule

// File: rtl/sertx_irqgen.sv
module sertx_irqgen (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_mode,
    input  logic mid_start,
    input  logic hold_empty,
    input  logic hold_full,
    input  logic wr_en,
    input  logic iid_rd,
    input  logic irq_en,
    output logic tx_irq,
    output logic dma_rdy
);
    typedef struct packed {
        logic pend;
        logic rdy;
    } ir_t;

    ir_t q, n;
    logic empty_evt;

    always_comb begin
        n         = q;
        empty_evt = mid_start && hold_empty;
        if (wr_en)                 n.pend = 1'b0;
        else if (iid_rd && q.pend) n.pend = 1'b0;
        else if (empty_evt)        n.pend = 1'b1;
        if (fifo_mode ? hold_full : wr_en) n.rdy = 1'b0;
        else if (empty_evt)                n.rdy = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.pend <= 1'b0;
            q.rdy  <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign tx_irq  = q.pend && irq_en;
    assign dma_rdy = q.rdy;

    // R10: a holding write always clears the interrupt
    a_r10_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_irq);

    // R8: the empty state only sets at the mid-start point with an empty store
    a_r8_set_at_mid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pend) |-> $past(mid_start && hold_empty));

    // R11: DMA ready only returns at the mid-start point
    a_r11_rdy_at_mid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_rdy) |-> $past(mid_start && hold_empty));

endmodule

// File: rtl/sertx_core.sv
module sertx_core #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int OVS   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          fifo_mode,
    input  logic [1:0]    char_len,
    input  logic          par_en,
    input  logic          par_even,
    input  logic          stop_long,
    input  logic          brk,
    input  logic          irq_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          iid_rd,
    output logic          tx_out,
    output logic          tx_irq,
    output logic          dma_rdy
);
    logic          hold_avail;
    logic          hold_full;
    logic          hold_pop;
    logic          mid_start;
    logic [DW-1:0] hold_data;

    sertx_hold #(.DEPTH(DEPTH), .DW(DW)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (fifo_mode),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (hold_pop),
        .rd_data   (hold_data),
        .avail     (hold_avail),
        .full      (hold_full)
    );

    sertx_shifter #(.OVS(OVS), .DW(DW)) shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .brk        (brk),
        .char_len   (char_len),
        .par_en     (par_en),
        .par_even   (par_even),
        .stop_long  (stop_long),
        .hold_avail (hold_avail),
        .hold_data  (hold_data),
        .hold_pop   (hold_pop),
        .mid_start  (mid_start),
        .tx_out     (tx_out)
    );

    sertx_irqgen irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_mode  (fifo_mode),
        .mid_start  (mid_start),
        .hold_empty (!hold_avail),
        .hold_full  (hold_full),
        .wr_en      (wr_en),
        .iid_rd     (iid_rd),
        .irq_en     (irq_en),
        .tx_irq     (tx_irq),
        .dma_rdy    (dma_rdy)
    );

endmodule

// File: tb/sertx_core_tb_top.sv
`timescale 1ns/1ps
module sertx_core_tb_top;

    typedef struct {
        logic [7:0] data;
        int         nb;
        bit         pen;
        bit         peven;
        int         stop_clks;
        bit         b2b;
    } item_t;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       fifo_mode = 1'b0;
    logic [1:0] char_len = 2'b11;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       stop_long = 1'b0;
    logic       brk = 1'b0;
    logic       irq_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       iid_rd = 1'b0;
    logic       tx_out, tx_irq, dma_rdy;

    sertx_core dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .fifo_mode(fifo_mode),
        .char_len(char_len), .par_en(par_en), .par_even(par_even), .stop_long(stop_long),
        .brk(brk), .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data), .iid_rd(iid_rd),
        .tx_out(tx_out), .tx_irq(tx_irq), .dma_rdy(dma_rdy)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 0;
    int    cyc = 0;
    item_t exp_q[$];
    bit    mon_en = 1;
    bit    mon_busy = 0;
    int    prev_end = 0;
    int    last_fall_cyc = 0;
    int    irq_rises = 0;
    int    irq_rise_cyc = 0;
    logic  irq_prev = 1'b0;
    string extra_req = "R6";

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            @(posedge clk);
            #1 baud_tick = ~baud_tick;
        end
    end

    always @(negedge clk) begin
        if (tx_irq === 1'b1 && irq_prev !== 1'b1) begin
            irq_rises    = irq_rises + 1;
            irq_rise_cyc = cyc;
        end
        irq_prev = tx_irq;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic push_exp(input logic [7:0] d, input bit b2b);
        item_t it;
        int    st;
        it.data  = d;
        it.nb    = 5 + int'(char_len);
        it.pen   = par_en;
        it.peven = par_even;
        st = !stop_long ? 16 : (char_len == 2'b00 ? 24 : 32);
        it.stop_clks = 2 * st;
        it.b2b   = b2b;
        exp_q.push_back(it);
    endtask

    task automatic put(input logic [7:0] d, input bit expect_tx, input bit b2b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        if (expect_tx) push_exp(d, b2b);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_iid();
        @(negedge clk);
        iid_rd = 1'b1;
        @(negedge clk);
        iid_rd = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (exp_q.size() != 0 || mon_busy);
        repeat (40) @(negedge clk);
    endtask

    // Scoreboard monitor: decodes each frame and compares it with the queue head
    initial begin : monitor
        item_t      it;
        int         fall, total, b, ones;
        logic [7:0] rx, msk;
        logic       pbit;
        bit         stop_ok;
        forever begin
            @(negedge clk);
            if (mon_en && rst_n && tx_out === 1'b0) begin
                mon_busy = 1;
                fall = cyc;
                last_fall_cyc = fall;
                if (exp_q.size() == 0) begin
                    chk(1'b0, extra_req, "character sent that was never accepted", 1, 0);
                    while (tx_out !== 1'b1) @(negedge clk);
                end else begin
                    it = exp_q.pop_front();
                    if (it.b2b) chk(fall == prev_end, "R4", "next start right after stop", fall, prev_end);
                    total = 32 * (1 + it.nb + int'(it.pen)) + it.stop_clks;
                    rx = '0;
                    pbit = 1'b0;
                    stop_ok = 1;
                    for (int r = 1; r < total; r++) begin
                        @(negedge clk);
                        if (r % 32 == 16) begin
                            b = r / 32;
                            if (b == 0) chk(tx_out === 1'b0, "R2", "start bit level", int'(tx_out), 0);
                            else if (b <= it.nb) rx[b-1] = tx_out;
                            else if (it.pen && b == it.nb + 1) pbit = tx_out;
                        end
                        if (r >= total - it.stop_clks && tx_out !== 1'b1) stop_ok = 0;
                    end
                    msk = 8'hFF >> (8 - it.nb);
                    chk(rx == (it.data & msk), "R2", "data bits LSB first", int'(rx), int'(it.data & msk));
                    if (it.pen) begin
                        ones = $countones(it.data & msk);
                        chk(pbit == (it.peven ? ones[0] : ~ones[0]), "R3", "parity bit",
                            int'(pbit), it.peven ? ones % 2 : 1 - ones % 2);
                    end
                    chk(stop_ok, "R4", "stop level held for full length", int'(stop_ok), 1);
                    prev_end = fall + total;
                end
                mon_busy = 0;
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin : main
        int t, r0;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(tx_out === 1'b1, "R1", "line high in reset", int'(tx_out), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(tx_out === 1'b1, "R1", "line high after reset", int'(tx_out), 1);
        chk(tx_irq === 1'b0, "R1", "interrupt low after reset", int'(tx_irq), 0);
        chk(dma_rdy === 1'b1, "R1", "DMA ready after reset", int'(dma_rdy), 1);

        // R9, R8, R11, R10: single write, single mode
        irq_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'hA5;
        push_exp(8'hA5, 0);
        @(negedge clk);
        wr_en = 1'b0;
        chk(dma_rdy === 1'b0, "R11", "DMA ready drops on write", int'(dma_rdy), 0);
        t = 0;
        while (tx_irq !== 1'b1 && t < 100) begin
            if (baud_tick) t++;
            @(negedge clk);
        end
        chk(t >= 16 && t <= 24, "R9", "ticks from first write to interrupt", t, 16);
        @(negedge clk);
        chk(irq_rise_cyc - last_fall_cyc == 16, "R8", "interrupt 8 ticks into start",
            irq_rise_cyc - last_fall_cyc, 16);
        chk(dma_rdy === 1'b1, "R11", "DMA ready back at mid start", int'(dma_rdy), 1);
        wait_idle();
        chk(tx_irq === 1'b1, "R10", "interrupt held until serviced", int'(tx_irq), 1);
        pulse_iid();
        chk(tx_irq === 1'b0, "R10", "identity read clears", int'(tx_irq), 0);

        // R8: two queued characters give one interrupt, at the second start
        fifo_mode = 1'b1;
        r0 = irq_rises;
        put(8'h3C, 1, 0);
        put(8'hC3, 1, 1);
        wait_idle();
        chk(irq_rises == r0 + 1, "R8", "one interrupt for a pair", irq_rises - r0, 1);
        chk(irq_rise_cyc - last_fall_cyc == 16, "R8", "interrupt at second start",
            irq_rise_cyc - last_fall_cyc, 16);
        put(8'h81, 1, 0);
        chk(tx_irq === 1'b0, "R10", "write clears interrupt", int'(tx_irq), 0);
        wait_idle();
        pulse_iid();
        chk(tx_irq === 1'b0, "R10", "identity read clears again", int'(tx_irq), 0);
        irq_en = 1'b0;
        put(8'h17, 1, 0);
        wait_idle();
        chk(tx_irq === 1'b0, "R8", "masked interrupt stays low", int'(tx_irq), 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk(tx_irq === 1'b1, "R8", "pending state shows on unmask", int'(tx_irq), 1);
        pulse_iid();

        // R2, R3, R4: framing sweep with back-to-back pairs
        for (int len = 0; len < 4; len++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int sl = 0; sl < 2; sl++) begin
                    @(negedge clk);
                    char_len = 2'(len);
                    par_en = (pm != 0);
                    par_even = (pm == 1);
                    stop_long = sl[0];
                    put(8'h5A ^ 8'(len * 37 + pm * 11 + sl * 5), 1, 0);
                    put(8'hB3 ^ 8'(len * 19 + pm * 7 + sl * 3), 1, 1);
                    wait_idle();
                end
            end
        end

        // R6, R11: 17-byte burst in queued mode, last one dropped
        char_len = 2'b11;
        par_en = 1'b0;
        stop_long = 1'b0;
        extra_req = "R6";
        for (int i = 0; i < 17; i++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_data = 8'(i * 17 + 3);
            if (i < 16) push_exp(8'(i * 17 + 3), i > 0);
        end
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        chk(dma_rdy === 1'b0, "R11", "DMA ready low when queue full", int'(dma_rdy), 0);
        wait_idle();
        repeat (400) @(negedge clk);
        chk(dma_rdy === 1'b1, "R11", "DMA ready after queue drains", int'(dma_rdy), 1);
        chk(exp_q.size() == 0, "R6", "all 16 queued bytes sent", exp_q.size(), 0);

        // R7: single mode drops a second write while occupied
        fifo_mode = 1'b0;
        extra_req = "R7";
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'h69;
        push_exp(8'h69, 0);
        @(negedge clk);
        wr_data = 8'h96;
        @(negedge clk);
        wr_en = 1'b0;
        chk(dma_rdy === 1'b0, "R11", "DMA ready low in single mode", int'(dma_rdy), 0);
        wait_idle();
        repeat (800) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "only the first byte sent", exp_q.size(), 0);

        // R5: break
        mon_en = 0;
        @(negedge clk);
        brk = 1'b1;
        repeat (3) @(negedge clk);
        chk(tx_out === 1'b0, "R5", "break drives line low", int'(tx_out), 0);
        repeat (50) @(negedge clk);
        chk(tx_out === 1'b0, "R5", "break holds line low", int'(tx_out), 0);
        brk = 1'b0;
        repeat (3) @(negedge clk);
        chk(tx_out === 1'b1, "R5", "line high after break", int'(tx_out), 1);
        mon_en = 1;

        report();
    end

endmodule